// File: doc/BRIEF.md
# Aliased Partial-Width Register File

This block holds eight 32-bit general-purpose registers. Each register can be reached through several views that overlap the same storage. The full view covers all 32 bits. The half view covers bits 15:0. The first four registers also have two byte views: a low byte over bits 7:0 and a high byte over bits 15:8. Writes through a narrow view merge into the stored word, so bits outside the view keep their values. Reads through a narrow view return the selected bits zero-extended.

The file has one write port and two read ports. Each port carries a 3-bit register index and a 2-bit view code. Reads are combinational. A write takes effect at the rising clock edge. A read of the register that is being written in the same cycle sees the merged result before the edge, so a consumer never picks up a stale value.

A byte view is not legal on registers 4 to 7. Such a request raises the invalid flag of that port. An invalid read returns zero. An invalid write leaves the file untouched.

Top module: `arf_top`

## Requirements
- R1: The file holds eight 32-bit registers with indices 0 to 7, in this order: accumulator, base, counter, data, source index, destination index, base pointer, stack pointer. A write with view code 2'b00 (full) replaces all 32 bits of the indexed register at the rising clock edge. A full-view read returns the whole word.
- R2: A write with view code 2'b01 (half) stores wr_data[15:0] into bits 15:0 and leaves bits 31:16 unchanged.
- R3: On registers 0 to 3, a write with view code 2'b10 (low byte) stores wr_data[7:0] into bits 7:0, and a write with view code 2'b11 (high byte) stores wr_data[7:0] into bits 15:8. Every other bit keeps its value.
- R4: A half-view read returns bits 15:0 of the register in data bits 15:0, with bits 31:16 zero.
- R5: A low-byte read returns bits 7:0 of the register, and a high-byte read returns bits 15:8, in data bits 7:0 with bits 31:8 zero.
- R6: A read that uses view code 2'b10 or 2'b11 on registers 4 to 7 drives that port's invalid output high and returns zero data. Any other read drives the invalid output low.
- R7: A write request (we high) that uses view code 2'b10 or 2'b11 on registers 4 to 7 drives wr_invalid high and changes no register. wr_invalid is low whenever we is low.
- R8: While a valid write is present, a read port whose index matches wr_idx returns, in the same cycle, the view of the merged value that the register will hold after the edge.
- R9: A synchronous active-high reset clears all eight registers to zero.
- R10: The two read ports are independent. Each returns its own index and view in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Write request |
| wr_idx | input | 3 | Write register index |
| wr_view | input | 2 | Write view code |
| wr_data | input | 32 | Write data; narrow views take the low bits |
| wr_invalid | output | 1 | Write request uses an illegal view |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_view | input | 2 | Read port 0 view code |
| rd0_data | output | 32 | Read port 0 data, zero-extended |
| rd0_invalid | output | 1 | Read port 0 request uses an illegal view |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_view | input | 2 | Read port 1 view code |
| rd1_data | output | 32 | Read port 1 data, zero-extended |
| rd1_invalid | output | 1 | Read port 1 request uses an illegal view |

## Verification
Read data and all three invalid flags are combinational. They are due in the same cycle as their inputs, and this includes the bypassed value during a write. A write's effect on storage shows up after exactly one rising edge, and reset clears the file at the first edge with rst high. The bench applies inputs at the falling edge and samples combinational results a nanosecond later, before the next rising edge. It confirms stored contents with a read in the cycle after the write edge.

// File: rtl/arf_pkg.sv
package arf_pkg;

    localparam int XLEN      = 32;
    localparam int NREGS     = 8;
    localparam int IDX_W     = $clog2(NREGS);
    localparam int HALF_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int BYTE_REGS = 4;
    localparam int VIEW_W    = 2;

    typedef logic [XLEN-1:0]  word_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [VIEW_W-1:0] {
        VIEW_FULL = 2'b00,
        VIEW_HALF = 2'b01,
        VIEW_LO8  = 2'b10,
        VIEW_HI8  = 2'b11
    } view_e;

    typedef struct packed {
        idx_t  idx;
        view_e view;
    } access_t;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        word_t data;
    } commit_t;

    function automatic logic is_byte_view(view_e v);
        return (v == VIEW_LO8) || (v == VIEW_HI8);
    endfunction

    function automatic logic view_legal(access_t a);
        return !(is_byte_view(a.view) && (int'(a.idx) >= BYTE_REGS));
    endfunction

    function automatic word_t merge_view(word_t old_w, word_t new_w, view_e v);
        word_t r;
        r = old_w;
        unique case (v)
            VIEW_FULL: r = new_w;
            VIEW_HALF: r[HALF_W-1:0] = new_w[HALF_W-1:0];
            VIEW_LO8:  r[BYTE_W-1:0] = new_w[BYTE_W-1:0];
            VIEW_HI8:  r[HALF_W-1:BYTE_W] = new_w[BYTE_W-1:0];
        endcase
        return r;
    endfunction

    function automatic word_t extract_view(word_t w, view_e v);
        word_t r;
        r = '0;
        unique case (v)
            VIEW_FULL: r = w;
            VIEW_HALF: r[HALF_W-1:0] = w[HALF_W-1:0];
            VIEW_LO8:  r[BYTE_W-1:0] = w[BYTE_W-1:0];
            VIEW_HI8:  r[BYTE_W-1:0] = w[HALF_W-1:BYTE_W];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/arf_write_path.sv
module arf_write_path
    import arf_pkg::*;
(
    input  logic                  we,
    input  access_t               acc,
    input  word_t                 wdata,
    input  logic [NREGS-1:0][XLEN-1:0] file,
    output commit_t               commit,
    output logic                  invalid
);
    logic  legal;
    word_t old_w;

    always_comb begin
        legal       = view_legal(acc);
        old_w       = file[acc.idx];
        invalid     = we && !legal;
        commit.en   = we && legal;
        commit.idx  = acc.idx;
        commit.data = merge_view(old_w, wdata, acc.view);
    end
endmodule

// File: rtl/arf_storage.sv
module arf_storage
    import arf_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  commit_t                    commit,
    output logic [NREGS-1:0][XLEN-1:0] file
);
    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                file[g] <= '0;
            end else if (commit.en && (int'(commit.idx) == g)) begin
                file[g] <= commit.data;
            end
        end
    end
endmodule

// File: rtl/arf_read_port.sv
module arf_read_port
    import arf_pkg::*;
(
    input  access_t                    acc,
    input  logic [NREGS-1:0][XLEN-1:0] file,
    input  commit_t                    commit,
    output word_t                      data,
    output logic                       invalid
);
    word_t src;
    logic  legal;

    always_comb begin
        legal   = view_legal(acc);
        src     = (commit.en && (commit.idx == acc.idx)) ? commit.data : file[acc.idx];
        invalid = !legal;
        data    = legal ? extract_view(src, acc.view) : '0;
    end
endmodule

// File: rtl/arf_top.sv
module arf_top
    import arf_pkg::*;
#(
    parameter int NUM_RD = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [2:0]  wr_idx,
    input  logic [1:0]  wr_view,
    input  logic [31:0] wr_data,
    output logic        wr_invalid,
    input  logic [2:0]  rd0_idx,
    input  logic [1:0]  rd0_view,
    output logic [31:0] rd0_data,
    output logic        rd0_invalid,
    input  logic [2:0]  rd1_idx,
    input  logic [1:0]  rd1_view,
    output logic [31:0] rd1_data,
    output logic        rd1_invalid
);
    logic [NREGS-1:0][XLEN-1:0] file_q;
    commit_t                    commit;
    access_t                    wr_acc;
    access_t                    rd_acc [NUM_RD];
    word_t                      rd_dat [NUM_RD];
    logic                       rd_inv [NUM_RD];

    assign wr_acc = '{idx: wr_idx, view: view_e'(wr_view)};
    assign rd_acc[0] = '{idx: rd0_idx, view: view_e'(rd0_view)};
    assign rd_acc[1] = '{idx: rd1_idx, view: view_e'(rd1_view)};

    arf_write_path u_wr (
        .we      (we),
        .acc     (wr_acc),
        .wdata   (wr_data),
        .file    (file_q),
        .commit  (commit),
        .invalid (wr_invalid)
    );

    arf_storage u_store (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .file   (file_q)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        arf_read_port u_rd (
            .acc     (rd_acc[p]),
            .file    (file_q),
            .commit  (commit),
            .data    (rd_dat[p]),
            .invalid (rd_inv[p])
        );
    end

    assign rd0_data    = rd_dat[0];
    assign rd0_invalid = rd_inv[0];
    assign rd1_data    = rd_dat[1];
    assign rd1_invalid = rd_inv[1];
endmodule

// File: rtl/arf_checker.sv
module arf_checker (
    input logic              clk,
    input logic              rst,
    input logic              we,
    input logic [2:0]        wr_idx,
    input logic [1:0]        wr_view,
    input logic              wr_invalid,
    input logic [2:0]        rd0_idx,
    input logic [1:0]        rd0_view,
    input logic [31:0]       rd0_data,
    input logic [1:0]        rd1_view,
    input logic [31:0]       rd1_data,
    input logic [7:0][31:0]  file
);
    logic rst_q = 1'b0;
    always_ff @(posedge clk) rst_q <= rst;

    logic wr_ok;
    assign wr_ok = we && !wr_invalid;

    p_reset_clears_r9: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (file == '0));

    p_half_keeps_upper_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && wr_view == 2'b01) |=>
        file[$past(wr_idx)][31:16] == $past(file[wr_idx][31:16]));

    p_lo8_keeps_rest_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && wr_view == 2'b10) |=>
        file[$past(wr_idx)][31:8] == $past(file[wr_idx][31:8]));

    p_hi8_keeps_rest_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && wr_view == 2'b11) |=>
        (file[$past(wr_idx)][31:16] == $past(file[wr_idx][31:16])) &&
        (file[$past(wr_idx)][7:0] == $past(file[wr_idx][7:0])));

    p_invalid_no_write_r7: assert property (@(posedge clk) disable iff (rst)
        wr_invalid |=> $stable(file));

    p_invalid_needs_we_r7: assert property (@(posedge clk) disable iff (rst)
        wr_invalid |-> we);

    p_half_zero_ext_r4: assert property (@(posedge clk) disable iff (rst)
        (rd0_view == 2'b01) |-> (rd0_data[31:16] == '0));

    p_byte_zero_ext_r5: assert property (@(posedge clk) disable iff (rst)
        (rd1_view[1]) |-> (rd1_data[31:8] == '0));

    p_bypass_matches_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && rd0_idx == wr_idx && rd0_view == 2'b00) |=>
        file[$past(wr_idx)] == $past(rd0_data));
endmodule

bind arf_top arf_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .we         (we),
    .wr_idx     (wr_idx),
    .wr_view    (wr_view),
    .wr_invalid (wr_invalid),
    .rd0_idx    (rd0_idx),
    .rd0_view   (rd0_view),
    .rd0_data   (rd0_data),
    .rd1_view   (rd1_view),
    .rd1_data   (rd1_data),
    .file       (file_q)
);

// File: tb/tb_arf_top.sv
`timescale 1ns/1ps
module tb_arf_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [1:0]  wr_view = '0;
    logic [31:0] wr_data = '0;
    logic        wr_invalid;
    logic [2:0]  rd0_idx = '0;
    logic [1:0]  rd0_view = '0;
    logic [31:0] rd0_data;
    logic        rd0_invalid;
    logic [2:0]  rd1_idx = '0;
    logic [1:0]  rd1_view = '0;
    logic [31:0] rd1_data;
    logic        rd1_invalid;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [8];

    always #2.5 clk = ~clk;

    arf_top dut (.*);

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] spec_merge(logic [31:0] o, logic [31:0] d, logic [1:0] v);
        case (v)
            2'b00:   return d;
            2'b01:   return {o[31:16], d[15:0]};
            2'b10:   return {o[31:8], d[7:0]};
            default: return {o[31:16], d[7:0], o[7:0]};
        endcase
    endfunction

    // drive a write at the falling edge, sample wr_invalid, let the rising edge commit it
    task automatic do_write(input logic [2:0] i, input logic [1:0] v,
                            input logic [31:0] d, output logic inv);
        @(negedge clk);
        we = 1'b1; wr_idx = i; wr_view = v; wr_data = d;
        #1 inv = wr_invalid;
        @(posedge clk);
        #1 we = 1'b0;
    endtask

    task automatic read0(input logic [2:0] i, input logic [1:0] v,
                         output logic [31:0] d, output logic inv);
        @(negedge clk);
        rd0_idx = i; rd0_view = v;
        #1 d = rd0_data; inv = rd0_invalid;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic inv;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        for (int k = 0; k < 8; k++) begin
            model[k] = '0;
            read0(k[2:0], 2'b00, d, inv);
            check($sformatf("R9 reset reg%0d", k), d, 32'h0);
        end
    endtask

    task automatic t_full();
        logic [31:0] d; logic inv;
        for (int k = 0; k < 8; k++) begin
            model[k] = 32'h1357_9BDF ^ (32'h0101_0101 * (k + 1)) ^ (k << 28);
            do_write(k[2:0], 2'b00, model[k], inv);
        end
        for (int k = 0; k < 8; k++) begin
            read0(k[2:0], 2'b00, d, inv);
            check($sformatf("R1 full reg%0d", k), d, model[k]);
        end
    endtask

    task automatic t_half();
        logic [31:0] d; logic inv;
        do_write(3'd5, 2'b01, 32'hFFFF_1234, inv);
        model[5] = spec_merge(model[5], 32'hFFFF_1234, 2'b01);
        read0(3'd5, 2'b00, d, inv);
        check("R2 half write keeps upper", d, model[5]);
        read0(3'd5, 2'b01, d, inv);
        check("R4 half read zero-extended", d, {16'h0, model[5][15:0]});
        do_write(3'd0, 2'b01, 32'h0000_BEEF, inv);
        model[0] = spec_merge(model[0], 32'h0000_BEEF, 2'b01);
        read0(3'd0, 2'b00, d, inv);
        check("R2 half write reg0", d, model[0]);
    endtask

    task automatic t_bytes();
        logic [31:0] d; logic inv;
        do_write(3'd2, 2'b10, 32'hFFFF_FFAB, inv);
        model[2] = spec_merge(model[2], 32'hFFFF_FFAB, 2'b10);
        read0(3'd2, 2'b00, d, inv);
        check("R3 low byte write", d, model[2]);
        do_write(3'd2, 2'b11, 32'h1111_11CD, inv);
        model[2] = spec_merge(model[2], 32'h1111_11CD, 2'b11);
        read0(3'd2, 2'b00, d, inv);
        check("R3 high byte write", d, model[2]);
        read0(3'd2, 2'b10, d, inv);
        check("R5 low byte read", d, 32'h0000_00AB);
        read0(3'd2, 2'b11, d, inv);
        check("R5 high byte read", d, 32'h0000_00CD);
        do_write(3'd3, 2'b11, 32'h0000_0077, inv);
        model[3] = spec_merge(model[3], 32'h0000_0077, 2'b11);
        read0(3'd3, 2'b00, d, inv);
        check("R3 high byte write reg3", d, model[3]);
    endtask

    task automatic t_invalid_read();
        logic [31:0] d; logic inv;
        read0(3'd6, 2'b11, d, inv);
        check("R6 hi8 reg6 invalid flag", {31'h0, inv}, 32'h1);
        check("R6 hi8 reg6 data zero", d, 32'h0);
        read0(3'd4, 2'b10, d, inv);
        check("R6 lo8 reg4 invalid flag", {31'h0, inv}, 32'h1);
        read0(3'd3, 2'b11, d, inv);
        check("R6 hi8 reg3 valid", {31'h0, inv}, 32'h0);
        read0(3'd7, 2'b01, d, inv);
        check("R6 half reg7 valid", {31'h0, inv}, 32'h0);
    endtask

    task automatic t_invalid_write();
        logic [31:0] d; logic inv;
        do_write(3'd7, 2'b10, 32'h0000_0055, inv);
        check("R7 lo8 reg7 wr_invalid", {31'h0, inv}, 32'h1);
        read0(3'd7, 2'b00, d, inv);
        check("R7 reg7 unchanged", d, model[7]);
        do_write(3'd5, 2'b11, 32'h0000_0099, inv);
        check("R7 hi8 reg5 wr_invalid", {31'h0, inv}, 32'h1);
        read0(3'd5, 2'b00, d, inv);
        check("R7 reg5 unchanged", d, model[5]);
        @(negedge clk);
        we = 1'b0; wr_idx = 3'd6; wr_view = 2'b11;
        #1 check("R7 no flag without we", {31'h0, wr_invalid}, 32'h0);
    endtask

    task automatic t_bypass();
        logic [31:0] nv;
        nv = spec_merge(model[1], 32'h0000_A5C3, 2'b01);
        @(negedge clk);
        we = 1'b1; wr_idx = 3'd1; wr_view = 2'b01; wr_data = 32'h0000_A5C3;
        rd0_idx = 3'd1; rd0_view = 2'b00;
        rd1_idx = 3'd1; rd1_view = 2'b11;
        #1;
        check("R8 bypass full view", rd0_data, nv);
        check("R8 bypass hi8 view", rd1_data, {24'h0, nv[15:8]});
        @(posedge clk);
        #1 we = 1'b0;
        model[1] = nv;
        @(negedge clk);
        #1 check("R8 stored after edge", rd0_data, model[1]);
    endtask

    task automatic t_dual();
        @(negedge clk);
        rd0_idx = 3'd6; rd0_view = 2'b00;
        rd1_idx = 3'd0; rd1_view = 2'b10;
        #1;
        check("R10 port0 reg6", rd0_data, model[6]);
        check("R10 port1 reg0 lo8", rd1_data, {24'h0, model[0][7:0]});
        check("R10 port1 valid", {31'h0, rd1_invalid}, 32'h0);
    endtask

    initial begin
        t_reset();
        t_full();
        t_half();
        t_bytes();
        t_invalid_read();
        t_invalid_write();
        t_bypass();
        t_dual();
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule